// File: doc/BRIEF.md
# Masked-Write Pad Function and Pull Register File

This block stores, for a parameterized number of I/O banks, a 2-bit function code and a 1-bit pull control for each of the 32 pins in every bank. It drives those settings out as flat per-pin vectors, to the pad multiplexers and the pad pull logic. It holds no pad or multiplexer logic itself.

Software writes 32-bit words. The upper half of each word is a per-bit enable for the lower half. A single write can therefore change one pin's field and leave every other field in the same register untouched, with no read-modify-write sequence. A write with every enable bit at zero does nothing.

Function registers and pull registers sit in two address windows, each starting at its own parameterized base. Any address outside both windows is dead: writes to it are dropped and reads of it return zero. Reads are registered, so the value appears one cycle after the request.

Top module: `pcfg_regfile`

## Requirements
- R1: After reset every stored bit is 0. So `func_sel` is all zeros, which is function code 0 (plain GPIO), and `pull_dis` is all zeros, meaning each pad uses its default pull. A read of any register returns 0.
- R2: On a write, data bit n (n = 0..15) replaces stored bit n only when `wdata[n+16]` is 1. Stored bits whose enable bit is 0 keep their value. Nothing changes in a cycle without `wr_en`.
- R3: The function field of pin p (0..31) in bank b is stored in the word at byte address FUNC_BASE + 16*b + 4*(p/8), in bits 2*(p%8)+1 down to 2*(p%8). It is driven on `func_sel[(32*b+p)*2 +: 2]`.
- R4: The pull bit of pin p in bank b is stored in the word at byte address PULL_BASE + 8*b + 4*(p/16), in bit p%16. It is driven on `pull_dis[32*b+p]`. A 1 turns the pull off; a 0 leaves the pad's default pull on.
- R5: A read pulses `rd_en` with an address. On the next clock edge `rdata` takes the stored 16 bits in its lower half and zeros in its upper half. `rdata` then holds that value until the next read.
- R6: A write to an address outside both windows changes no state. A read from such an address returns 0. Address bits 1:0 are ignored.
- R7: A write whose bits 31:16 are all zero leaves all state unchanged.
- R8: A write to a function register leaves every pull bit unchanged, and a write to a pull register leaves every function field unchanged. A write to one bank's register changes no other bank's outputs.
- R9: When a read and a write target the same register in the same cycle, the read returns the value from before the write.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Bits 31:16 are the enables, bits 15:0 are the data |
| rdata | output | 32 | Registered read data; upper half is zero |
| func_sel | output | NUM_BANKS*64 | 2-bit function code per pin |
| pull_dis | output | NUM_BANKS*32 | Pull-disable bit per pin |

## Verification
The hardest case to reach from the ports is a partial masked update that lands on top of other fields already set in the same word. This case shows whether the enables truly protect neighbouring bits or whether the update only looks right starting from zero. The stimulus first fills whole registers with dense patterns. It then issues narrow masked writes whose data bits outside the mask are deliberately the inverse of the stored bits. It also fires a read and a write at the same register in one cycle to expose the ordering of read data against the update.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
package pcfg_pkg;
    localparam int PINS_PER_BANK  = 32;
    localparam int FUNC_W         = 2;
    localparam int DATA_W         = 16;
    localparam int FUNC_WORDS     = (PINS_PER_BANK * FUNC_W) / DATA_W;  // per bank
    localparam int PULL_WORDS     = PINS_PER_BANK / DATA_W;             // per bank
    localparam int FUNC_STRIDE_B  = 16;                                 // bytes per bank
    localparam int PULL_STRIDE_B  = 8;                                  // bytes per bank

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_FUNC = 2'd1,
        WIN_PULL = 2'd2
    } win_e;
endpackage

// File: rtl/pcfg_addr_dec.sv
`timescale 1ns/1ps
module pcfg_addr_dec
    import pcfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 4,
    parameter int FUNC_BASE = 'h000,
    parameter int PULL_BASE = 'h100,
    localparam int FW_N     = NUM_BANKS * FUNC_WORDS,
    localparam int PW_N     = NUM_BANKS * PULL_WORDS,
    localparam int FIDX_W   = (FW_N > 1) ? $clog2(FW_N) : 1,
    localparam int PIDX_W   = (PW_N > 1) ? $clog2(PW_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [FIDX_W-1:0] fidx,
    output logic [PIDX_W-1:0] pidx
);
    localparam logic [ADDR_W:0] F_LO = (ADDR_W+1)'(FUNC_BASE);
    localparam logic [ADDR_W:0] F_HI = (ADDR_W+1)'(FUNC_BASE + NUM_BANKS * FUNC_STRIDE_B);
    localparam logic [ADDR_W:0] P_LO = (ADDR_W+1)'(PULL_BASE);
    localparam logic [ADDR_W:0] P_HI = (ADDR_W+1)'(PULL_BASE + NUM_BANKS * PULL_STRIDE_B);

    logic [ADDR_W:0] a_ext, off_f, off_p;
    logic            in_f, in_p;

    assign a_ext = {1'b0, addr};
    assign off_f = a_ext - F_LO;
    assign off_p = a_ext - P_LO;
    assign in_f  = (a_ext >= F_LO) && (a_ext < F_HI);
    assign in_p  = (a_ext >= P_LO) && (a_ext < P_HI);

    always_comb begin
        win  = WIN_NONE;
        fidx = off_f[FIDX_W+1:2];
        pidx = off_p[PIDX_W+1:2];
        if (in_f)      win = WIN_FUNC;
        else if (in_p) win = WIN_PULL;
    end

    logic unused_bits;
    assign unused_bits = ^{off_f, off_p};

    // R6: a decoded index never points past the storage it selects
    always_comb begin
        if (win == WIN_FUNC) a_fidx_range_r6: assert (int'(fidx) < FW_N);
        if (win == WIN_PULL) a_pidx_range_r6: assert (int'(pidx) < PW_N);
    end
endmodule

// File: rtl/pcfg_mask_merge.sv
`timescale 1ns/1ps
module pcfg_mask_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] en,
    output logic [W-1:0] merged
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged[i] = en[i] ? new_val[i] : old_val[i];
    end
endmodule

// File: rtl/pcfg_regfile.sv
`timescale 1ns/1ps
module pcfg_regfile
    import pcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int FUNC_BASE = 'h000,
    parameter int PULL_BASE = 'h100,
    localparam int FW_N     = NUM_BANKS * FUNC_WORDS,
    localparam int PW_N     = NUM_BANKS * PULL_WORDS,
    localparam int FIDX_W   = (FW_N > 1) ? $clog2(FW_N) : 1,
    localparam int PIDX_W   = (PW_N > 1) ? $clog2(PW_N) : 1,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [NPINS*FUNC_W-1:0] func_sel,
    output logic [NPINS-1:0]        pull_dis
);
    typedef struct packed {
        logic [FW_N-1:0][DATA_W-1:0] func;
        logic [PW_N-1:0][DATA_W-1:0] pull;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t            st_d, st_q;
    win_e              win;
    logic [FIDX_W-1:0] fidx;
    logic [PIDX_W-1:0] pidx;
    logic [DATA_W-1:0] cur_word, merged_word;

    pcfg_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
        .FUNC_BASE(FUNC_BASE), .PULL_BASE(PULL_BASE)
    ) dec_i (
        .addr(addr), .win(win), .fidx(fidx), .pidx(pidx)
    );

    pcfg_mask_merge #(.W(DATA_W)) merge_i (
        .old_val(cur_word),
        .new_val(wdata[DATA_W-1:0]),
        .en     (wdata[31:16]),
        .merged (merged_word)
    );

    always_comb begin
        st_d     = st_q;
        cur_word = '0;
        case (win)
            WIN_FUNC: cur_word = st_q.func[fidx];
            WIN_PULL: cur_word = st_q.pull[pidx];
            default:  cur_word = '0;
        endcase
        if (wr_en) begin
            if (win == WIN_FUNC) st_d.func[fidx] = merged_word;
            if (win == WIN_PULL) st_d.pull[pidx] = merged_word;
        end
        if (rd_en) st_d.rdata = cur_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = {16'h0000, st_q.rdata};
    assign func_sel = st_q.func;
    assign pull_dis = st_q.pull;

    p_zero_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[31:16] == 16'h0) |=> ($stable(func_sel) && $stable(pull_dis)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(func_sel) && $stable(pull_dis)));

    p_outside_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win == WIN_NONE) |=> ($stable(func_sel) && $stable(pull_dis)));

    p_outside_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win == WIN_NONE) |=> (rdata == 32'h0));

    p_func_keeps_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win == WIN_FUNC) |=> $stable(pull_dis));

    p_pull_keeps_func_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win == WIN_PULL) |=> $stable(func_sel));

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/pcfg_regfile_tb_top.sv
`timescale 1ns/1ps
module pcfg_regfile_tb_top;
    localparam int NB    = 4;
    localparam int AW    = 12;
    localparam int FBASE = 'h000;
    localparam int PBASE = 'h100;
    localparam int NP    = NB * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NP*2-1:0] func_sel;
    logic [NP-1:0]   pull_dis;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_func [NB*4];
    logic [15:0] m_pull [NB*2];

    always #5 clk = ~clk;

    pcfg_regfile #(.NUM_BANKS(NB), .ADDR_W(AW), .FUNC_BASE(FBASE), .PULL_BASE(PBASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .func_sel(func_sel), .pull_dis(pull_dis)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model update follows R2/R3/R4 address layout
    task automatic model_write(input int a, input logic [31:0] d);
        int w;
        if (a >= FBASE && a < FBASE + NB*16) begin
            w = (a - FBASE) / 4;
            m_func[w] = (m_func[w] & ~d[31:16]) | (d[15:0] & d[31:16]);
        end else if (a >= PBASE && a < PBASE + NB*8) begin
            w = (a - PBASE) / 4;
            m_pull[w] = (m_pull[w] & ~d[31:16]) | (d[15:0] & d[31:16]);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        model_write(a, d);
    endtask

    task automatic do_read(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_outputs(input string req);
        logic [NP*2-1:0] ef;
        logic [NP-1:0]   ep;
        for (int i = 0; i < NB*4; i++) ef[i*16 +: 16] = m_func[i];
        for (int i = 0; i < NB*2; i++) ep[i*16 +: 16] = m_pull[i];
        check({req, " func_sel"}, 256'(func_sel), 256'(ef));
        check({req, " pull_dis"}, 256'(pull_dis), 256'(ep));
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 func_sel zero", 256'(func_sel), 256'(0));
        check("R1 pull_dis zero", 256'(pull_dis), 256'(0));
        do_read(FBASE + 'h14, v);
        check("R1 read zero", 256'(v), 256'(0));
    endtask

    task automatic t_func_field;
        logic [31:0] v;
        // bank 1 pin 13 -> 0x14 bits 11:10
        do_write(FBASE + 'h14, 32'h0C00_0C00);
        check("R3 bank1 pin13 field", 256'(func_sel[(32+13)*2 +: 2]), 256'(2'd3));
        check("R3 neighbour pin12", 256'(func_sel[(32+12)*2 +: 2]), 256'(2'd0));
        do_read(FBASE + 'h14, v);
        check("R5 readback", 256'(v), 256'(32'h0000_0C00));
        check_outputs("R3");
    endtask

    task automatic t_pull_field;
        logic [31:0] v;
        // bank 2 pin 20 -> 0x114 bit 4
        do_write(PBASE + 'h14, 32'h0010_0010);
        check("R4 bank2 pin20 pull", 256'(pull_dis[64+20]), 256'(1'b1));
        do_read(PBASE + 'h14, v);
        check("R5 pull readback", 256'(v), 256'(32'h0000_0010));
        check_outputs("R4");
    endtask

    task automatic t_partial_mask;
        logic [31:0] v;
        do_write(FBASE + 'h08, 32'hFFFF_A5C3);
        // change only bits 5:4, inverse elsewhere in data
        do_write(FBASE + 'h08, 32'h0030_5A0C);
        do_read(FBASE + 'h08, v);
        check("R2 partial mask", 256'(v), 256'(32'h0000_A5C3));
        do_write(FBASE + 'h08, 32'h0030_0010);
        do_read(FBASE + 'h08, v);
        check("R2 masked field set", 256'(v), 256'(32'h0000_A5D3));
        check_outputs("R2");
    endtask

    task automatic t_zero_mask;
        logic [31:0] v;
        do_write(FBASE + 'h08, 32'h0000_FFFF);
        do_read(FBASE + 'h08, v);
        check("R7 zero mask", 256'(v), 256'(32'h0000_A5D3));
        check_outputs("R7");
    endtask

    task automatic t_out_of_window;
        logic [31:0] v;
        do_write(FBASE + NB*16, 32'hFFFF_FFFF);
        do_write(PBASE + NB*8, 32'hFFFF_FFFF);
        do_write('h0FC, 32'hFFFF_FFFF);
        check_outputs("R6 write ignored");
        do_read(PBASE + NB*8, v);
        check("R6 read zero", 256'(v), 256'(0));
        do_write(FBASE + 'h16, 32'h0003_0002);  // low bits ignored -> word 0x14
        check_outputs("R6 low addr bits");
    endtask

    task automatic t_isolation;
        do_write(PBASE + 'h00, 32'hFFFF_FFFF);
        check_outputs("R8 pull write");
        do_write(FBASE + 'h30, 32'hFFFF_1234);
        check_outputs("R8 func write");
    endtask

    task automatic t_last_pin;
        // bank 3 pin 31: func 0x3C bits 15:14, pull 0x11C bit 15
        do_write(FBASE + 'h3C, 32'hC000_8000);
        check("R3 last pin func", 256'(func_sel[(96+31)*2 +: 2]), 256'(2'd2));
        do_write(PBASE + 'h1C, 32'h8000_8000);
        check("R4 last pin pull", 256'(pull_dis[127]), 256'(1'b1));
        check_outputs("R3 R4 last bank");
    endtask

    task automatic t_read_during_write;
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = AW'(FBASE + 'h24); wdata = 32'hFFFF_BEEF;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        v = rdata;
        model_write(FBASE + 'h24, 32'hFFFF_BEEF);
        check("R9 old value returned", 256'(v), 256'(0));
        do_read(FBASE + 'h24, v);
        check("R9 new value after", 256'(v), 256'(32'h0000_BEEF));
    endtask

    task automatic t_sweep;
        logic [31:0] v;
        for (int i = 0; i < NB*4; i++) do_write(FBASE + 4*i, {16'hFFFF, 16'(i * 16'h1357)});
        for (int i = 0; i < NB*2; i++) do_write(PBASE + 4*i, {16'hFFFF, 16'(~(i * 16'h0F0F))});
        check_outputs("R3 R4 sweep");
        do_read(PBASE + 4, v);
        check("R5 sweep read", 256'(v), 256'({16'h0, m_pull[1]}));
    endtask

    initial begin
        for (int i = 0; i < NB*4; i++) m_func[i] = '0;
        for (int i = 0; i < NB*2; i++) m_pull[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_func_field();
        t_pull_field();
        t_partial_mask();
        t_zero_mask();
        t_out_of_window();
        t_isolation();
        t_last_pin();
        t_read_during_write();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule